// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fixed-Level Parity

This block serialises one character at a time onto a single line for an asynchronous link. A frame holds a low start bit, five to eight data bits sent least significant first, an optional parity bit and one or two high stop bits. Between frames the line rests high. Each bit lasts exactly one baud period. A baud-tick enable from an external divider marks the end of every bit, so the block has no divider of its own and no queue.

The parity bit can be computed as even or odd over the data bits in use. It can also be pinned to a fixed level: a constant high (mark) or a constant low (space). A separate break control pulls the line low as long as it is held. While break is asserted, the frame sequencer keeps running, so a frame in flight still completes and reports done. The parity value for the present data and control inputs is also driven on its own port, so a receiver can use the same logic to check parity.

A host drives the character and the line settings, pulses the start strobe while the block is idle, then waits for the done pulse. The shape of the frame is captured when the strobe is accepted.

Top module: `async_tx`

## Requirements
- R1: After reset, and at any time the block is idle with break clear, txd is 1, busy is 0 and done is 0.
- R2: A frame starts only on a startStrobe seen while idle. From the next clock, busy is 1 and txd carries the start bit (0) until the next baudTick. A startStrobe while busy is ignored and does not queue a frame.
- R3: After the start bit, the data bits go out least significant bit first, one per baudTick. The count is 5 + wordLen, so codes 0, 1, 2, 3 give 5, 6, 7, 8 bits.
- R4: With parityEn=1 and stickPar=0, a parity bit follows the data. With evenSel=1 it makes the number of ones in the data bits plus parity even. With evenSel=0 it makes that number odd.
- R5: With parityEn=1 and stickPar=1, the parity bit is 0 when evenSel=1 and 1 when evenSel=0, whatever the data.
- R6: With parityEn=0, no parity bit is sent and stickPar and evenSel have no effect on the frame.
- R7: One stop bit (txd=1) is sent when twoStop=0, and two when twoStop=1.
- R8: While breakCtl is 1, txd is 0 whatever the state. The frame keeps advancing on baudTick and still ends with done.
- R9: done is 1 for exactly one clock, starting at the clock edge that consumes the last stop bit's baudTick. busy falls at that same edge.
- R10: wordLen, twoStop, parityEn, evenSel, stickPar and dataIn are captured when the frame starts. Changing them during a frame does not change that frame.
- R11: parityBit always shows the R4/R5 parity of the live dataIn and control inputs, for use by a receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startStrobe | input | 1 | Request to send dataIn (accepted only when idle) |
| dataIn | input | 8 | Character to send; unused high bits ignored |
| baudTick | input | 1 | One-clock pulse marking the end of each bit time |
| wordLen | input | 2 | Data bit count minus 5 |
| twoStop | input | 1 | 1 selects two stop bits |
| parityEn | input | 1 | 1 inserts a parity bit |
| evenSel | input | 1 | 1 selects even parity (or space when stickPar is set) |
| stickPar | input | 1 | 1 pins the parity bit to a fixed level |
| breakCtl | input | 1 | 1 holds txd low |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at frame end |
| parityBit | output | 1 | Parity of live dataIn under live settings |

## Verification
Break override and frame sequencing can act in the same cycle. The bench asserts breakCtl part way through a frame and checks that txd stays 0 through every bit time that remains. It then checks that done still arrives on the expected stop tick and that txd returns high once break is cleared. A start strobe and new character settings can also arrive during a baud tick in the middle of a frame. The bench drives them during the tick and compares every later bit with the frame captured at the start.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [1:0] {
    LINE_MARK  = 2'd0,
    LINE_START = 2'd1,
    LINE_DATA  = 2'd2,
    LINE_PAR   = 2'd3
  } lineSel_e;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e lineSel;
  } txStrobes_t;

endpackage

// File: rtl/async_tx_parity.sv
module async_tx_parity #(
  parameter int MAX_BITS = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2,
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic [MAX_BITS-1:0] dataVal,
  input  logic [LEN_W-1:0]    lenCode,
  input  logic                evenSel,
  input  logic                stickPar,
  output logic                parOut
);

  logic [CNT_W-1:0]    bitCount;
  logic [MAX_BITS-1:0] masked;
  logic                xorAll;

  assign bitCount = CNT_W'(MIN_BITS) + CNT_W'(lenCode);

  for (genvar g = 0; g < MAX_BITS; g++) begin : gMask
    assign masked[g] = dataVal[g] & (CNT_W'(g) < bitCount);
  end

  assign xorAll = ^masked;

  always_comb begin
    if (stickPar) parOut = ~evenSel;
    else if (evenSel) parOut = xorAll;
    else parOut = ~xorAll;
  end

endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2,
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStrobe,
  input  logic             baudTick,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             twoStop,
  input  logic             parityEn,
  output txStrobes_t       strobes,
  output logic             busy,
  output logic             done
);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } state_e;

  state_e           stateQ, stateD;
  logic [CNT_W-1:0] lenQ, bitCntQ, bitCntD;
  logic             stop2Q, parEnQ, stopCntQ, stopCntD, doneD;

  always_comb begin
    stateD        = stateQ;
    bitCntD       = bitCntQ;
    stopCntD      = stopCntQ;
    doneD         = 1'b0;
    strobes.load  = 1'b0;
    strobes.shift = 1'b0;
    unique case (stateQ)
      S_IDLE: if (startStrobe) begin
        strobes.load = 1'b1;
        stateD       = S_START;
      end
      S_START: if (baudTick) begin
        stateD  = S_DATA;
        bitCntD = '0;
      end
      S_DATA: if (baudTick) begin
        strobes.shift = 1'b1;
        if (bitCntQ == lenQ - 1'b1) begin
          stateD   = parEnQ ? S_PAR : S_STOP;
          stopCntD = 1'b0;
        end else begin
          bitCntD = bitCntQ + 1'b1;
        end
      end
      S_PAR: if (baudTick) begin
        stateD   = S_STOP;
        stopCntD = 1'b0;
      end
      S_STOP: if (baudTick) begin
        if (stopCntQ == stop2Q) begin
          stateD = S_IDLE;
          doneD  = 1'b1;
        end else begin
          stopCntD = 1'b1;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (stateQ)
      S_START: strobes.lineSel = LINE_START;
      S_DATA:  strobes.lineSel = LINE_DATA;
      S_PAR:   strobes.lineSel = LINE_PAR;
      default: strobes.lineSel = LINE_MARK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      bitCntQ  <= '0;
      stopCntQ <= 1'b0;
      lenQ     <= CNT_W'(MAX_BITS);
      stop2Q   <= 1'b0;
      parEnQ   <= 1'b0;
      done     <= 1'b0;
    end else begin
      stateQ   <= stateD;
      bitCntQ  <= bitCntD;
      stopCntQ <= stopCntD;
      done     <= doneD;
      if (strobes.load) begin
        lenQ   <= CNT_W'(MIN_BITS) + CNT_W'(wordLen);
        stop2Q <= twoStop;
        parEnQ <= parityEn;
      end
    end
  end

  assign busy = (stateQ != S_IDLE);

endmodule

// File: rtl/async_tx_dp.sv
module async_tx_dp
  import async_tx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobes_t          strobes,
  input  logic [MAX_BITS-1:0] dataIn,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                evenSel,
  input  logic                stickPar,
  input  logic                breakCtl,
  output logic                txd,
  output logic                parityBit
);

  logic [MAX_BITS-1:0] shiftQ;
  logic                parQ;
  logic                lineBit;

  async_tx_parity #(
    .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)
  ) u_parity (
    .dataVal (dataIn),
    .lenCode (wordLen),
    .evenSel (evenSel),
    .stickPar(stickPar),
    .parOut  (parityBit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      parQ   <= 1'b0;
    end else if (strobes.load) begin
      shiftQ <= dataIn;
      parQ   <= parityBit;
    end else if (strobes.shift) begin
      shiftQ <= shiftQ >> 1;
    end
  end

  always_comb begin
    unique case (strobes.lineSel)
      LINE_START: lineBit = 1'b0;
      LINE_DATA:  lineBit = shiftQ[0];
      LINE_PAR:   lineBit = parQ;
      default:    lineBit = 1'b1;
    endcase
  end

  assign txd = breakCtl ? 1'b0 : lineBit;

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startStrobe,
  input  logic [MAX_BITS-1:0] dataIn,
  input  logic                baudTick,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                twoStop,
  input  logic                parityEn,
  input  logic                evenSel,
  input  logic                stickPar,
  input  logic                breakCtl,
  output logic                txd,
  output logic                busy,
  output logic                done,
  output logic                parityBit
);

  txStrobes_t strobes;

  async_tx_ctrl #(
    .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startStrobe(startStrobe),
    .baudTick   (baudTick),
    .wordLen    (wordLen),
    .twoStop    (twoStop),
    .parityEn   (parityEn),
    .strobes    (strobes),
    .busy       (busy),
    .done       (done)
  );

  async_tx_dp #(
    .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dataIn   (dataIn),
    .wordLen  (wordLen),
    .evenSel  (evenSel),
    .stickPar (stickPar),
    .breakCtl (breakCtl),
    .txd      (txd),
    .parityBit(parityBit)
  );

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk,
  input logic rstN,
  input logic startStrobe,
  input logic baudTick,
  input logic breakCtl,
  input logic txd,
  input logic busy,
  input logic done
);

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !breakCtl) |-> txd);

  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startStrobe));

  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !breakCtl) |-> !txd);

  p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !baudTick) |=> busy);

  p_break_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    breakCtl |-> !txd);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy) && $past(baudTick)));

endmodule

bind async_tx async_tx_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startStrobe(startStrobe),
  .baudTick   (baudTick),
  .breakCtl   (breakCtl),
  .txd        (txd),
  .busy       (busy),
  .done       (done)
);

// File: tb/async_tx_bench.sv
`timescale 1ns/1ps
module async_tx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStrobe = 1'b0;
  logic [7:0] dataIn = '0;
  logic       baudTick = 1'b0;
  logic [1:0] wordLen = '0;
  logic       twoStop = 1'b0, parityEn = 1'b0, evenSel = 1'b0, stickPar = 1'b0;
  logic       breakCtl = 1'b0;
  logic       txd, busy, done, parityBit;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  async_tx u_async_tx (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .dataIn(dataIn),
    .baudTick(baudTick), .wordLen(wordLen), .twoStop(twoStop),
    .parityEn(parityEn), .evenSel(evenSel), .stickPar(stickPar),
    .breakCtl(breakCtl), .txd(txd), .busy(busy), .done(done),
    .parityBit(parityBit)
  );

  // {data, wordLen code, twoStop, parityEn, evenSel, stickPar, expected parity}
  localparam logic [14:0] VEC [0:8] = '{
    {8'hA5, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'hA5, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h1F, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h3C, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h7F, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h01, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'hC3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hFF, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h55, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // mode: 0 plain, 1 break from bit 2, 2 strobe and settings change at bit 2
  task automatic sendFrame(input logic [14:0] v, input int mode);
    logic [7:0] d;
    logic       exp [0:12];
    string      tag [0:12];
    int         n, nData;
    d = v[14:7];
    nData = 5 + int'(v[6:5]);
    exp[0] = 1'b0; tag[0] = "R2 start";
    n = 1;
    for (int b = 0; b < nData; b++) begin
      exp[n] = d[b]; tag[n] = "R3 data"; n++;
    end
    if (v[3]) begin
      exp[n] = v[0]; tag[n] = v[1] ? "R5 stick parity" : "R4 parity"; n++;
    end
    exp[n] = 1'b1; tag[n] = v[3] ? "R7 stop" : "R6 R7 stop without parity"; n++;
    if (v[4]) begin exp[n] = 1'b1; tag[n] = "R7 second stop"; n++; end

    @(negedge clk);
    dataIn = d; wordLen = v[6:5]; twoStop = v[4];
    parityEn = v[3]; evenSel = v[2]; stickPar = v[1];
    #1;
    if (v[3]) check(parityBit == v[0], "R11 parityBit", parityBit, v[0]);
    startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
    check(busy == 1'b1, "R2 busy after strobe", busy, 1);
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (mode == 1 && i >= 2) begin
        breakCtl = 1'b1; #1;
        check(txd == 1'b0, "R8 break holds txd", txd, 0);
      end else begin
        check(txd == exp[i], tag[i], txd, exp[i]);
      end
      if (i < n - 1) check(busy == 1'b1, "R9 busy in frame", busy, 1);
      if (mode == 2 && i == 2) begin
        startStrobe = 1'b1; dataIn = ~d; wordLen = ~v[6:5]; twoStop = ~v[4];
        parityEn = ~v[3]; evenSel = ~v[2]; stickPar = ~v[1];
      end
      baudTick = 1'b1;
      @(negedge clk);
      baudTick = 1'b0; startStrobe = 1'b0;
      if (i == n - 1) begin
        check(done == 1'b1, "R9 done at end", done, 1);
        check(busy == 1'b0, "R9 busy falls", busy, 0);
      end else begin
        check(done == 1'b0, "R9 no early done", done, 0);
      end
      @(negedge clk);
    end
    check(done == 1'b0, "R9 done one clock", done, 0);
    if (mode == 1) begin
      breakCtl = 1'b0; #1;
    end
    check(txd == 1'b1, "R1 idle mark", txd, 1);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R2 no queued frame", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R1 reset txd", txd, 1);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 idle busy", busy, 0);

    // ticks while idle must not start anything (R2)
    baudTick = 1'b1; repeat (2) @(negedge clk); baudTick = 1'b0;
    check(busy == 1'b0, "R2 tick alone", busy, 0);

    for (int k = 0; k < 9; k++) sendFrame(VEC[k], 0);

    // break while idle (R8)
    @(negedge clk); breakCtl = 1'b1; #1;
    check(txd == 1'b0, "R8 break idle", txd, 0);
    @(negedge clk); breakCtl = 1'b0; #1;
    check(txd == 1'b1, "R8 break released", txd, 1);

    // break part way through a frame (R8)
    sendFrame(VEC[3], 1);
    // strobe and settings change during a frame (R2, R10)
    sendFrame(VEC[0], 2);
    sendFrame(VEC[7], 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule